// File: doc/BRIEF.md
# Word Arithmetic Unit with Overflow Register

This unit is the arithmetic and logic stage of a small 16-bit processor. Each cycle in which `in_valid` is high, it takes a 4-bit operation code and two 16-bit operands, A and B. One clock later it presents the result word and a new value for the processor's separate overflow register. It also presents a write strobe for each of the two, a skip flag for the conditional tests and the cycle cost of the operation. Fetching operands, writing values back and sequencing instructions belong to the surrounding pipeline. The unit only states what should be written and whether the next instruction should be skipped.

The overflow value depends on the operation: a carry bit for addition, a borrow bit for subtraction, the upper product half for multiplication, a 16-bit binary fraction of the quotient for division, and the bits pushed out of the word for the two shifts. Every other operation leaves the overflow register untouched by holding its strobe low.

Top module: `wau_core`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 at the next edge, including `out_valid`, both strobes, `skip` and `cost`.
- R2: The outputs hold the operation sampled at the previous rising edge. When `in_valid` was low at that edge, `out_valid`, `res`, `ovf_val`, both strobes, `skip` and `cost` are all 0.
- R3: Opcode 2 (add) gives the low 16 bits of A+B. The overflow value is 1 if the true sum is above 0xFFFF and 0 otherwise. Both strobes are high.
- R4: Opcode 3 (subtract) gives the low 16 bits of A-B. The overflow value is 1 when B is greater than A and 0 otherwise. Both strobes are high.
- R5: Opcode 4 (multiply) gives product bits 15:0 as the result and product bits 31:16 as the overflow value. Both strobes are high.
- R6: Opcode 5 (divide) with a nonzero B gives floor(A/B) as the result and the low 16 bits of floor(A*65536/B) as the overflow value. With B zero, both values are 0. Both strobes are high in either case.
- R7: Opcode 6 (modulo) gives A mod B, or 0 when B is zero. `wr_res` is high, while `wr_ovf` is low and `ovf_val` is 0.
- R8: Opcode 7 (shift left) treats A, zero-extended to 32 bits and shifted left by B, as a 32-bit value W. The result is W[15:0] and the overflow value is W[31:16]. When B is 32 or more, both values are 0.
- R9: Opcode 8 (shift right) forms W = ({A,16'h0000} >> B) on 32 bits. The result is W[31:16] and the overflow value is W[15:0]. When B is 32 or more, both values are 0.
- R10: Opcode 1 (move) gives B, and opcodes 9, 10 and 11 give A AND B, A OR B and A XOR B. For all four, `wr_res` is high, `wr_ovf` is low and `ovf_val` is 0.
- R11: Opcodes 12 to 15 test A==B, A!=B, A>B unsigned, and (A AND B)!=0, in that order. `skip` is high exactly when the test is false. Both strobes are low and `res` and `ovf_val` are 0.
- R12: `cost` is 1 for opcodes 1, 9, 10 and 11; 2 for opcodes 2, 3, 4, 7 and 8; 3 for opcodes 5 and 6; and 2 plus `skip` for opcodes 12 to 15.
- R13: Opcode 0 is reserved and produces all-zero data, strobes, `skip` and `cost`, while `out_valid` still follows `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| out_valid | output | 1 | Outputs hold a completed operation |
| res | output | 16 | Result word |
| ovf_val | output | 16 | New value for the overflow register |
| wr_res | output | 1 | Write `res` to the destination |
| wr_ovf | output | 1 | Write `ovf_val` to the overflow register |
| skip | output | 1 | Conditional test failed; skip next instruction |
| cost | output | 2 | Cycle cost of the operation |

## Verification
The properties assume that `op`, `in_valid` and `rst` are driven to known values at every rising edge. They also assume that an operation's code can be recovered one cycle later from the sampled input, because the properties tie the registered strobes, `skip` and `cost` back to the opcode. The stimulus changes inputs only at falling edges and keeps every input at a defined value from time zero. It covers each opcode with both its ordinary and its zero or out-of-range divisor and shift operands.

// File: rtl/wau_pkg.sv
package wau_pkg;

  typedef enum logic [3:0] {
    OP_RSV   = 4'd0,
    OP_MOVE  = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_MUL   = 4'd4,
    OP_DIV   = 4'd5,
    OP_MOD   = 4'd6,
    OP_SHL   = 4'd7,
    OP_SHR   = 4'd8,
    OP_AND   = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11,
    OP_IFEQ  = 4'd12,
    OP_IFNE  = 4'd13,
    OP_IFGT  = 4'd14,
    OP_IFANY = 4'd15
  } op_e;

  localparam int COST_LOGIC = 1;
  localparam int COST_ARITH = 2;
  localparam int COST_DIVMOD = 3;
  localparam int COST_COND = 2;

endpackage

// File: rtl/wau_addmul.sv
module wau_addmul #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum_res,
  output logic [DW-1:0] sum_ovf,
  output logic [DW-1:0] dif_res,
  output logic [DW-1:0] dif_ovf,
  output logic [DW-1:0] mul_res,
  output logic [DW-1:0] mul_ovf
);
  localparam int PW = 2 * DW;

  logic [DW:0]   sum_w;
  logic [DW:0]   dif_w;
  logic [PW-1:0] prod_w;

  always_comb begin
    sum_w  = {1'b0, a} + {1'b0, b};
    dif_w  = {1'b0, a} - {1'b0, b};
    prod_w = PW'(a) * PW'(b);
  end

  assign sum_res = sum_w[DW-1:0];
  assign sum_ovf = DW'(sum_w[DW]);
  assign dif_res = dif_w[DW-1:0];
  assign dif_ovf = DW'(dif_w[DW]);
  assign mul_res = prod_w[DW-1:0];
  assign mul_ovf = prod_w[PW-1:DW];
endmodule

// File: rtl/wau_divmod.sv
module wau_divmod #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] div_res,
  output logic [DW-1:0] div_ovf,
  output logic [DW-1:0] mod_res
);
  localparam int PW = 2 * DW;

  logic          den_zero;
  logic [PW-1:0] num_w;
  logic [PW-1:0] quo_w;

  assign den_zero = (b == '0);
  assign num_w    = {a, {DW{1'b0}}};

  // One wide division yields both the integer part (upper half)
  // and the binary fraction (lower half) of A/B.
  always_comb begin
    if (den_zero) begin
      quo_w   = '0;
      mod_res = '0;
    end else begin
      quo_w   = num_w / PW'(b);
      mod_res = a % b;
    end
  end

  assign div_res = quo_w[PW-1:DW];
  assign div_ovf = quo_w[DW-1:0];
endmodule

// File: rtl/wau_shift.sv
module wau_shift #(
  parameter int DW   = 16,
  parameter bit LEFT = 1'b1
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sh_res,
  output logic [DW-1:0] sh_ovf
);
  localparam int PW  = 2 * DW;
  localparam int SAW = $clog2(PW);

  logic           too_far;
  logic [SAW-1:0] amt;
  logic [PW-1:0]  wide_w;

  assign too_far = (b >= DW'(PW));
  assign amt     = b[SAW-1:0];

  generate
    if (LEFT) begin : g_left
      always_comb begin
        wide_w = too_far ? '0 : ({{DW{1'b0}}, a} << amt);
      end
      assign sh_res = wide_w[DW-1:0];
      assign sh_ovf = wide_w[PW-1:DW];
    end else begin : g_right
      always_comb begin
        wide_w = too_far ? '0 : ({a, {DW{1'b0}}} >> amt);
      end
      assign sh_res = wide_w[PW-1:DW];
      assign sh_ovf = wide_w[DW-1:0];
    end
  endgenerate
endmodule

// File: rtl/wau_logcmp.sv
module wau_logcmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] and_res,
  output logic [DW-1:0] or_res,
  output logic [DW-1:0] xor_res,
  output logic          is_eq,
  output logic          is_gt,
  output logic          any_bit
);
  assign and_res = a & b;
  assign or_res  = a | b;
  assign xor_res = a ^ b;
  assign is_eq   = (a == b);
  assign is_gt   = (a > b);
  assign any_bit = |and_res;
endmodule

// File: rtl/wau_core.sv
module wau_core #(
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          out_valid,
  output logic [DW-1:0] res,
  output logic [DW-1:0] ovf_val,
  output logic          wr_res,
  output logic          wr_ovf,
  output logic          skip,
  output logic [CW-1:0] cost
);
  import wau_pkg::*;

  logic [DW-1:0] sum_res, sum_ovf, dif_res, dif_ovf, mul_res, mul_ovf;
  logic [DW-1:0] div_res, div_ovf, mod_res;
  logic [DW-1:0] shl_res, shl_ovf, shr_res, shr_ovf;
  logic [DW-1:0] and_res, or_res, xor_res;
  logic          is_eq, is_gt, any_bit;

  wau_addmul #(.DW(DW)) u_addmul (
    .a(opa), .b(opb),
    .sum_res(sum_res), .sum_ovf(sum_ovf),
    .dif_res(dif_res), .dif_ovf(dif_ovf),
    .mul_res(mul_res), .mul_ovf(mul_ovf)
  );

  wau_divmod #(.DW(DW)) u_divmod (
    .a(opa), .b(opb),
    .div_res(div_res), .div_ovf(div_ovf), .mod_res(mod_res)
  );

  wau_shift #(.DW(DW), .LEFT(1'b1)) u_shl (
    .a(opa), .b(opb), .sh_res(shl_res), .sh_ovf(shl_ovf)
  );

  wau_shift #(.DW(DW), .LEFT(1'b0)) u_shr (
    .a(opa), .b(opb), .sh_res(shr_res), .sh_ovf(shr_ovf)
  );

  wau_logcmp #(.DW(DW)) u_logcmp (
    .a(opa), .b(opb),
    .and_res(and_res), .or_res(or_res), .xor_res(xor_res),
    .is_eq(is_eq), .is_gt(is_gt), .any_bit(any_bit)
  );

  logic [DW-1:0] n_res, n_ovf;
  logic          n_wr, n_wo, n_skip;
  logic [CW-1:0] n_cost;

  always_comb begin
    n_res  = '0;
    n_ovf  = '0;
    n_wr   = 1'b0;
    n_wo   = 1'b0;
    n_skip = 1'b0;
    n_cost = '0;
    unique case (op_e'(op))
      OP_MOVE: begin n_res = opb;     n_wr = 1'b1; n_cost = CW'(COST_LOGIC); end
      OP_AND:  begin n_res = and_res; n_wr = 1'b1; n_cost = CW'(COST_LOGIC); end
      OP_OR:   begin n_res = or_res;  n_wr = 1'b1; n_cost = CW'(COST_LOGIC); end
      OP_XOR:  begin n_res = xor_res; n_wr = 1'b1; n_cost = CW'(COST_LOGIC); end
      OP_ADD: begin
        n_res = sum_res; n_ovf = sum_ovf; n_wr = 1'b1; n_wo = 1'b1;
        n_cost = CW'(COST_ARITH);
      end
      OP_SUB: begin
        n_res = dif_res; n_ovf = dif_ovf; n_wr = 1'b1; n_wo = 1'b1;
        n_cost = CW'(COST_ARITH);
      end
      OP_MUL: begin
        n_res = mul_res; n_ovf = mul_ovf; n_wr = 1'b1; n_wo = 1'b1;
        n_cost = CW'(COST_ARITH);
      end
      OP_SHL: begin
        n_res = shl_res; n_ovf = shl_ovf; n_wr = 1'b1; n_wo = 1'b1;
        n_cost = CW'(COST_ARITH);
      end
      OP_SHR: begin
        n_res = shr_res; n_ovf = shr_ovf; n_wr = 1'b1; n_wo = 1'b1;
        n_cost = CW'(COST_ARITH);
      end
      OP_DIV: begin
        n_res = div_res; n_ovf = div_ovf; n_wr = 1'b1; n_wo = 1'b1;
        n_cost = CW'(COST_DIVMOD);
      end
      OP_MOD: begin
        n_res = mod_res; n_wr = 1'b1; n_cost = CW'(COST_DIVMOD);
      end
      OP_IFEQ:  n_skip = !is_eq;
      OP_IFNE:  n_skip = is_eq;
      OP_IFGT:  n_skip = !is_gt;
      OP_IFANY: n_skip = !any_bit;
      default: ;
    endcase
    if (op >= 4'(OP_IFEQ)) begin
      n_cost = CW'(COST_COND) + CW'(n_skip);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      ovf_val   <= '0;
      wr_res    <= 1'b0;
      wr_ovf    <= 1'b0;
      skip      <= 1'b0;
      cost      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res     <= n_res;
        ovf_val <= n_ovf;
        wr_res  <= n_wr;
        wr_ovf  <= n_wo;
        skip    <= n_skip;
        cost    <= n_cost;
      end else begin
        res     <= '0;
        ovf_val <= '0;
        wr_res  <= 1'b0;
        wr_ovf  <= 1'b0;
        skip    <= 1'b0;
        cost    <= '0;
      end
    end
  end
endmodule

// File: rtl/wau_checker.sv
module wau_checker #(
  parameter int DW = 16,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic          out_valid,
  input logic [DW-1:0] ovf_val,
  input logic          wr_res,
  input logic          wr_ovf,
  input logic          skip,
  input logic [CW-1:0] cost
);
  import wau_pkg::*;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !wr_res && !wr_ovf); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !wr_res && !wr_ovf && !skip && cost == '0); // R2

  AST_CARRY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) == 4'(OP_ADD) |-> ovf_val <= DW'(1)); // R3

  AST_MOD_KEEPS_OVF: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) == 4'(OP_MOD) |-> wr_res && !wr_ovf); // R7

  AST_SKIP_ONLY_COND: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) < 4'(OP_IFEQ) |-> !skip); // R11

  AST_COND_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) >= 4'(OP_IFEQ) |-> !wr_res && !wr_ovf); // R11

  AST_COND_COST: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) >= 4'(OP_IFEQ) |-> cost == CW'(2) + CW'(skip)); // R12

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) == 4'(OP_RSV) |-> !wr_res && !wr_ovf && cost == '0); // R13
endmodule

bind wau_core wau_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .ovf_val(ovf_val), .wr_res(wr_res),
  .wr_ovf(wr_ovf), .skip(skip), .cost(cost)
);

// File: tb/wau_core_tb.sv
module wau_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] opa = 16'd0;
  logic [15:0] opb = 16'd0;
  logic        out_valid, wr_res, wr_ovf, skip;
  logic [15:0] res, ovf_val;
  logic [1:0]  cost;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wau_core u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .out_valid(out_valid), .res(res), .ovf_val(ovf_val), .wr_res(wr_res),
    .wr_ovf(wr_ovf), .skip(skip), .cost(cost)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic [15:0] ovf;
    logic        wr;
    logic        wo;
    logic        sk;
    logic [1:0]  cost;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{"R3",  4'd2,  16'hFFFF, 16'h0001, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R3",  4'd2,  16'h1234, 16'h1111, 16'h2345, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R4",  4'd3,  16'h0005, 16'h0007, 16'hFFFE, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R4",  4'd3,  16'h0007, 16'h0005, 16'h0002, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R5",  4'd4,  16'h1234, 16'h0100, 16'h3400, 16'h0012, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R5",  4'd4,  16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R6",  4'd5,  16'h0007, 16'h0002, 16'h0003, 16'h8000, 1'b1, 1'b1, 1'b0, 2'd3},
    '{"R6",  4'd5,  16'h1234, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3},
    '{"R6",  4'd5,  16'h0001, 16'h0003, 16'h0000, 16'h5555, 1'b1, 1'b1, 1'b0, 2'd3},
    '{"R7",  4'd6,  16'h0017, 16'h0005, 16'h0003, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3},
    '{"R7",  4'd6,  16'h1234, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3},
    '{"R8",  4'd7,  16'h8001, 16'h0001, 16'h0002, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R8",  4'd7,  16'h00FF, 16'h0014, 16'h0000, 16'h0FF0, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R8",  4'd7,  16'h1234, 16'h0010, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R8",  4'd7,  16'hFFFF, 16'h0020, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R9",  4'd8,  16'h8001, 16'h0001, 16'h4000, 16'h8000, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R9",  4'd8,  16'h1234, 16'h0014, 16'h0000, 16'h0123, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R9",  4'd8,  16'hFFFF, 16'h0040, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2},
    '{"R10", 4'd1,  16'h1111, 16'hBEEF, 16'hBEEF, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1},
    '{"R10", 4'd9,  16'hF0F0, 16'h3C3C, 16'h3030, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1},
    '{"R10", 4'd10, 16'hF0F0, 16'h0F00, 16'hFFF0, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1},
    '{"R10", 4'd11, 16'hFFFF, 16'h1234, 16'hEDCB, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1},
    '{"R11", 4'd12, 16'h0005, 16'h0005, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2},
    '{"R11", 4'd12, 16'h0005, 16'h0006, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3},
    '{"R11", 4'd13, 16'h0005, 16'h0005, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3},
    '{"R11", 4'd13, 16'h0005, 16'h0006, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2},
    '{"R11", 4'd14, 16'h0006, 16'h0005, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2},
    '{"R11", 4'd14, 16'h0005, 16'h0005, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3},
    '{"R11", 4'd14, 16'h8000, 16'h7FFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2},
    '{"R11", 4'd15, 16'h00F0, 16'h0F00, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3},
    '{"R11", 4'd15, 16'h0010, 16'h0011, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2},
    '{"R13", 4'd0,  16'h1234, 16'h5678, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  task automatic check_vec(input vec_t v);
    n_checks++;
    if (out_valid !== 1'b1 || res !== v.res || ovf_val !== v.ovf ||
        wr_res !== v.wr || wr_ovf !== v.wo || skip !== v.sk || cost !== v.cost) begin
      n_fail++;
      $display("FAIL %s (cost R12) op=%0d a=%h b=%h: got v=%b res=%h ovf=%h wr=%b wo=%b sk=%b cost=%0d, exp v=1 res=%h ovf=%h wr=%b wo=%b sk=%b cost=%0d",
               v.tag, v.op, v.a, v.b, out_valid, res, ovf_val, wr_res, wr_ovf, skip, cost,
               v.res, v.ovf, v.wr, v.wo, v.sk, v.cost);
    end
  endtask

  task automatic check_idle(input string req);
    n_checks++;
    if (out_valid !== 1'b0 || res !== 16'h0 || ovf_val !== 16'h0 || wr_res !== 1'b0 ||
        wr_ovf !== 1'b0 || skip !== 1'b0 || cost !== 2'd0) begin
      n_fail++;
      $display("FAIL %s: got v=%b res=%h ovf=%h wr=%b wo=%b sk=%b cost=%0d, exp all zero",
               req, out_valid, res, ovf_val, wr_res, wr_ovf, skip, cost);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] o, input logic [15:0] a,
                       input logic [15:0] b);
    in_valid = v;
    op = o;
    opa = a;
    opb = b;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    drive(1'b1, 4'd2, 16'hFFFF, 16'hFFFF);
    repeat (3) @(negedge clk);
    check_idle("R1");

    rst = 1'b0;
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) check_vec(VECS[i-1]);
      if (i < NV) drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
      else drive(1'b0, 4'd2, 16'hFFFF, 16'h0001);
    end

    // Invalid cycle with a live-looking add on the inputs
    @(negedge clk);
    check_idle("R2");

    // Valid op, then a dropped valid: outputs must clear
    drive(1'b1, 4'd12, 16'h0001, 16'h0002);
    @(negedge clk);
    check_vec('{"R11", 4'd12, 16'h0001, 16'h0002, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3});
    drive(1'b0, 4'd12, 16'h0001, 16'h0002);
    @(negedge clk);
    check_idle("R2");

    // Reset during a valid operation
    drive(1'b1, 4'd4, 16'hFFFF, 16'hFFFF);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    check_vec('{"R5", 4'd4, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE, 1'b1, 1'b1, 1'b0, 2'd2});
    drive(1'b0, 4'd0, 16'h0000, 16'h0000);
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule